// File: doc/BRIEF.md
# Write-Through Invalidating Snoop Cache Controller

This block is the coherence controller for one small direct-mapped, write-through cache that sits on a shared bus with other caching agents. Each line carries a tag and a single presence bit, so a line is either valid or invalid. The processor side hands over one read or write at a time through a valid/ready handshake and receives a one-cycle completion pulse. Read hits are answered from the local line. Read misses and all writes become bus transactions.

The bus side requests ownership, drives one transaction and waits for it to complete. A separate snoop port observes every transaction placed on the bus by other agents. A snooped write to an address held in the cache clears that line. Many caches can therefore share a line for reading, but any write removes every other copy. Writes that miss do not allocate a line. If a snooped invalidation lands on the line that the current lookup is using, the snoop wins and the lookup is retried.

Top module: `wti_cache`

## Requirements
- R1: After reset every line is invalid, `proc_ready` is high, and `bus_req` and `rsp_valid` are low; the first read of any address goes to the bus.
- R2: A read that hits a valid line with a matching tag puts nothing on the bus. It returns the line data with `rsp_valid` high in the cycle after the lookup cycle, which is two clock edges after acceptance.
- R3: A read that misses raises `bus_req` with `bus_cmd`=0 (read) and the full request address. It returns `bus_rdata` and fills the line, so a repeat read of the same address then hits.
- R4: Every write, hit or miss, raises `bus_req` with `bus_cmd`=1 (write), the request address and the write data. A write that hits also updates the local data, and the line stays valid.
- R5: A write that misses does not allocate a line, so a later read of that address goes to the bus.
- R6: A snooped write (`snp_valid` high, `snp_cmd`=1) whose address matches a valid line makes that line invalid, so the next read of it goes to the bus and returns memory's current value.
- R7: A snooped read (`snp_cmd`=0), and a snooped write to the same index with a different tag, leave the line valid and its data unchanged.
- R8: Once raised, `bus_req`, `bus_cmd`, `bus_addr` and `bus_wdata` hold steady until a cycle in which both `bus_gnt` and `bus_ack` are high. The transaction completes in that cycle.
- R9: A snooped write that invalidates the line being looked up in that same cycle takes priority. The lookup is repeated and is then treated as a miss.
- R10: Only one operation is in flight: `proc_ready` is low from acceptance until after the response, and `rsp_valid` is a single-cycle pulse for every accepted request, reads and writes alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| proc_valid | input | 1 | Processor request present |
| proc_ready | output | 1 | Controller can accept a request |
| proc_we | input | 1 | 1 = write, 0 = read |
| proc_addr | input | ADDR_W | Request address |
| proc_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Completion pulse |
| rsp_rdata | output | DATA_W | Read result, valid with rsp_valid on reads |
| bus_req | output | 1 | Bus ownership request, held for the transaction |
| bus_gnt | input | 1 | Bus ownership granted |
| bus_cmd | output | 1 | 0 = read, 1 = write |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write data on the bus |
| bus_ack | input | 1 | Memory completes the transaction (counted only with bus_gnt) |
| bus_rdata | input | DATA_W | Read data from memory, valid with bus_ack |
| snp_valid | input | 1 | Another agent's transaction is on the bus |
| snp_cmd | input | 1 | 0 = read, 1 = write, for the snooped transaction |
| snp_addr | input | ADDR_W | Address of the snooped transaction |

## Verification
The assertions assume a bus in which transactions are atomic: `snp_valid` is never high while this cache holds `bus_gnt`, and `bus_ack` comes only with `bus_gnt`. They also assume the processor keeps a request steady until it is accepted. The bench grants the bus only to the pending request and drives snoops only when the controller is idle or in its lookup cycle, never during its own granted cycle. Snooped writes also update the bench memory, which mirrors another agent writing through to it.

// File: rtl/wti_pkg.sv
package wti_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_BUS  = 2'd2,
        ST_RESP = 2'd3
    } ctl_state_e;

    localparam logic CMD_RD = 1'b0;
    localparam logic CMD_WR = 1'b1;

endpackage

// File: rtl/wti_tag_store.sv
module wti_tag_store #(
    parameter int IDX_W = 2,
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] look_idx,
    input  logic [TAG_W-1:0] look_tag,
    output logic             look_hit,
    input  logic             snp_valid,
    input  logic             snp_wr,
    input  logic [IDX_W-1:0] snp_idx,
    input  logic [TAG_W-1:0] snp_tag,
    output logic             snp_hit,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] valid_q, valid_d;
    logic [TAG_W-1:0] tag_q [LINES];
    logic [TAG_W-1:0] tag_d [LINES];

    always_comb begin
        look_hit = valid_q[look_idx] && (tag_q[look_idx] == look_tag);
        snp_hit  = snp_valid && snp_wr && valid_q[snp_idx] && (tag_q[snp_idx] == snp_tag);
    end

    always_comb begin
        valid_d = valid_q;
        tag_d   = tag_q;
        if (fill_en) begin
            valid_d[fill_idx] = 1'b1;
            tag_d[fill_idx]   = fill_tag;
        end
        // snoop invalidation is applied last so it wins over a fill
        if (snp_hit) begin
            valid_d[snp_idx] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < LINES; i++) begin
                tag_q[i] <= '0;
            end
        end else begin
            valid_q <= valid_d;
            tag_q   <= tag_d;
        end
    end

    // R6
    snoop_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_hit |=> !valid_q[$past(snp_idx)]);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> valid_q == '0);

endmodule

// File: rtl/wti_data_store.sv
module wti_data_store #(
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    localparam int LINES = 1 << IDX_W;

    logic [DATA_W-1:0] line_q [LINES];
    logic [DATA_W-1:0] line_d [LINES];

    always_comb begin
        line_d = line_q;
        if (wr_en) begin
            line_d[wr_idx] = wr_data;
        end
        rd_data = line_q[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                line_q[i] <= '0;
            end
        end else begin
            line_q <= line_d;
        end
    end

endmodule

// File: rtl/wti_ctrl.sv
module wti_ctrl
    import wti_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              proc_valid,
    output logic              proc_ready,
    input  logic              proc_we,
    input  logic [ADDR_W-1:0] proc_addr,
    input  logic [DATA_W-1:0] proc_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [IDX_W-1:0]  look_idx,
    output logic [TAG_W-1:0]  look_tag,
    input  logic              look_hit,
    input  logic [DATA_W-1:0] look_data,
    input  logic              snp_hit,
    input  logic [IDX_W-1:0]  snp_idx,
    output logic              fill_en,
    output logic              dwr_en,
    output logic [DATA_W-1:0] dwr_data
);
    typedef struct packed {
        ctl_state_e        state;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } ctl_regs_t;

    ctl_regs_t r_q, r_d;
    logic      conflict;
    logic      bus_done;

    always_comb begin
        look_idx  = r_q.addr[IDX_W-1:0];
        look_tag  = r_q.addr[ADDR_W-1:IDX_W];
        conflict  = snp_hit && (snp_idx == look_idx);
        bus_done  = bus_gnt && bus_ack;

        r_d        = r_q;
        proc_ready = 1'b0;
        rsp_valid  = 1'b0;
        bus_req    = 1'b0;
        fill_en    = 1'b0;
        dwr_en     = 1'b0;
        dwr_data   = r_q.wdata;

        unique case (r_q.state)
            ST_IDLE: begin
                proc_ready = 1'b1;
                if (proc_valid) begin
                    r_d.we    = proc_we;
                    r_d.addr  = proc_addr;
                    r_d.wdata = proc_wdata;
                    r_d.state = ST_LOOK;
                end
            end
            ST_LOOK: begin
                if (conflict) begin
                    r_d.state = ST_LOOK;
                end else if (!r_q.we && look_hit) begin
                    r_d.rdata = look_data;
                    r_d.state = ST_RESP;
                end else begin
                    r_d.state = ST_BUS;
                end
            end
            ST_BUS: begin
                bus_req = 1'b1;
                if (bus_done) begin
                    if (!r_q.we) begin
                        fill_en   = 1'b1;
                        dwr_en    = 1'b1;
                        dwr_data  = bus_rdata;
                        r_d.rdata = bus_rdata;
                    end else if (look_hit) begin
                        dwr_en   = 1'b1;
                        dwr_data = r_q.wdata;
                    end
                    r_d.state = ST_RESP;
                end
            end
            ST_RESP: begin
                rsp_valid = 1'b1;
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase

        bus_cmd   = r_q.we ? CMD_WR : CMD_RD;
        bus_addr  = r_q.addr;
        bus_wdata = r_q.wdata;
        rsp_rdata = r_q.rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, we: 1'b0, addr: '0, wdata: '0, rdata: '0};
        end else begin
            r_q <= r_d;
        end
    end

    // R8
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !(bus_gnt && bus_ack)) |=>
            (bus_req && $stable(bus_addr) && $stable(bus_cmd) && $stable(bus_wdata)));

    // R10
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R10
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_valid && proc_ready) |=> !proc_ready);

    // R2
    hit_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_LOOK && !r_q.we && look_hit && !conflict) |=> (!bus_req && rsp_valid));

    // R9
    snoop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_LOOK && conflict) |=> (!rsp_valid && !bus_req));

    // R10
    one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(proc_ready && (bus_req || rsp_valid)));

endmodule

// File: rtl/wti_cache.sv
module wti_cache
    import wti_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              proc_valid,
    output logic              proc_ready,
    input  logic              proc_we,
    input  logic [ADDR_W-1:0] proc_addr,
    input  logic [DATA_W-1:0] proc_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic              snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  look_idx;
    logic [TAG_W-1:0]  look_tag;
    logic              look_hit;
    logic [DATA_W-1:0] look_data;
    logic              snp_hit;
    logic              fill_en;
    logic              dwr_en;
    logic [DATA_W-1:0] dwr_data;
    logic              snp_wr;

    assign snp_wr = (snp_cmd == CMD_WR);

    wti_tag_store #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_idx  (look_idx),
        .look_tag  (look_tag),
        .look_hit  (look_hit),
        .snp_valid (snp_valid),
        .snp_wr    (snp_wr),
        .snp_idx   (snp_addr[IDX_W-1:0]),
        .snp_tag   (snp_addr[ADDR_W-1:IDX_W]),
        .snp_hit   (snp_hit),
        .fill_en   (fill_en),
        .fill_idx  (look_idx),
        .fill_tag  (look_tag)
    );

    wti_data_store #(
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W)
    ) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (dwr_en),
        .wr_idx  (look_idx),
        .wr_data (dwr_data),
        .rd_idx  (look_idx),
        .rd_data (look_data)
    );

    wti_ctrl #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .proc_valid (proc_valid),
        .proc_ready (proc_ready),
        .proc_we    (proc_we),
        .proc_addr  (proc_addr),
        .proc_wdata (proc_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .bus_req    (bus_req),
        .bus_gnt    (bus_gnt),
        .bus_cmd    (bus_cmd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_ack    (bus_ack),
        .bus_rdata  (bus_rdata),
        .look_idx   (look_idx),
        .look_tag   (look_tag),
        .look_hit   (look_hit),
        .look_data  (look_data),
        .snp_hit    (snp_hit),
        .snp_idx    (snp_addr[IDX_W-1:0]),
        .fill_en    (fill_en),
        .dwr_en     (dwr_en),
        .dwr_data   (dwr_data)
    );

endmodule

// File: tb/wti_cache_test.sv
module wti_cache_test;
    localparam int AW    = 8;
    localparam int IW    = 2;
    localparam int DW    = 16;
    localparam int LINES = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          proc_valid = 1'b0;
    logic          proc_ready;
    logic          proc_we = 1'b0;
    logic [AW-1:0] proc_addr = '0;
    logic [DW-1:0] proc_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          bus_req;
    logic          bus_gnt = 1'b0;
    logic          bus_cmd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_ack = 1'b0;
    logic [DW-1:0] bus_rdata = '0;
    logic          snp_valid = 1'b0;
    logic          snp_cmd = 1'b0;
    logic [AW-1:0] snp_addr = '0;

    int compared = 0;
    int mismatched = 0;

    // behavioural reference: memory plus presence/tag/data per line
    logic [DW-1:0]    mem [1 << AW];
    bit               m_valid [LINES];
    logic [AW-IW-1:0] m_tag [LINES];
    logic [DW-1:0]    m_data [LINES];

    always #5 clk = ~clk;

    wti_cache #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .proc_valid(proc_valid), .proc_ready(proc_ready), .proc_we(proc_we),
        .proc_addr(proc_addr), .proc_wdata(proc_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit m_hit(input logic [AW-1:0] a);
        return m_valid[a[IW-1:0]] && (m_tag[a[IW-1:0]] == a[AW-1:IW]);
    endfunction

    // another agent's transaction seen on the snoop port
    function automatic void m_snoop(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        if (wr) begin
            mem[a] = d;
            if (m_hit(a)) m_valid[a[IW-1:0]] = 1'b0;
        end
    endfunction

    task automatic snoop(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = wr; snp_addr = a;
        m_snoop(wr, a, d);
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    // one processor operation; optional snoop during the lookup cycle; gd = grant delay
    task automatic op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                      input int gd, input bit look_snp, input logic [AW-1:0] sa,
                      input logic [DW-1:0] sd, input string req);
        bit exp_bus, hit, saw_bus, granted, done;
        logic [DW-1:0] exp_rd;
        int lat, wait_cnt;
        @(negedge clk);
        proc_valid = 1'b1; proc_we = we; proc_addr = a; proc_wdata = wd;
        while (!proc_ready) @(negedge clk);
        @(negedge clk);
        proc_valid = 1'b0;
        if (look_snp) begin
            snp_valid = 1'b1; snp_cmd = 1'b1; snp_addr = sa;
            m_snoop(1'b1, sa, sd);
        end
        hit     = m_hit(a);
        exp_bus = we || !hit;
        exp_rd  = hit ? m_data[a[IW-1:0]] : mem[a];
        saw_bus = 0; granted = 0; done = 0; lat = 0; wait_cnt = 0;
        for (int cyc = 0; cyc < 60 && !done; cyc++) begin
            @(negedge clk);
            lat++;
            snp_valid = 1'b0;
            bus_gnt = 1'b0; bus_ack = 1'b0;
            if (rsp_valid) begin
                done = 1;
                if (!we) chk(rsp_rdata == exp_rd, req, "read data", rsp_rdata, exp_rd);
                if (!we && !exp_bus) chk(lat == 1, "R2", "hit latency", lat, 1);
                chk(saw_bus == exp_bus, req, "bus used", saw_bus, exp_bus);
            end else begin
                chk(!proc_ready, "R10", "ready while busy", proc_ready, 0);
                if (bus_req && !granted) begin
                    saw_bus = 1;
                    chk(bus_cmd == we && bus_addr == a && (!we || bus_wdata == wd),
                        "R8", "bus fields", {bus_cmd, bus_addr}, {we, a});
                    if (wait_cnt == gd) begin
                        bus_gnt = 1'b1; bus_ack = 1'b1; bus_rdata = mem[a];
                        granted = 1;
                        if (we) mem[a] = wd;
                    end
                    wait_cnt++;
                end else if (saw_bus && !granted) begin
                    chk(0, "R8", "bus_req dropped early", 0, 1);
                end
            end
        end
        chk(done, req, "response seen", done, 1);
        bus_gnt = 1'b0; bus_ack = 1'b0;
        @(negedge clk);
        chk(!rsp_valid, "R10", "response width", rsp_valid, 0);
        // update reference
        if (!we && !hit) begin
            m_valid[a[IW-1:0]] = 1'b1; m_tag[a[IW-1:0]] = a[AW-1:IW]; m_data[a[IW-1:0]] = exp_rd;
        end
        if (we && hit) m_data[a[IW-1:0]] = wd;
    endtask

    initial begin
        #200000;
        chk(0, "ALL", "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < (1 << AW); i++) mem[i] = DW'(i * 37 + 5);
        for (int i = 0; i < LINES; i++) begin m_valid[i] = 0; m_tag[i] = '0; m_data[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(proc_ready && !bus_req && !rsp_valid, "R1", "idle outputs",
            {proc_ready, bus_req, rsp_valid}, 3'b100);
        op(0, 8'h00, 0, 0, 0, 0, 0, "R1");          // first read misses
        op(0, 8'h12, 0, 2, 0, 0, 0, "R3");          // read miss, delayed grant
        op(0, 8'h12, 0, 0, 0, 0, 0, "R2");          // repeat read hits
        op(1, 8'h12, 16'hBEEF, 1, 0, 0, 0, "R4");   // write hit goes to bus
        op(0, 8'h12, 0, 0, 0, 0, 0, "R4");          // hit returns written data
        op(1, 8'h35, 16'h1234, 0, 0, 0, 0, "R4");   // write miss
        op(0, 8'h35, 0, 0, 0, 0, 0, "R5");          // no allocate: read misses
        op(0, 8'h35, 0, 0, 0, 0, 0, "R2");
        snoop(1, 8'h35, 16'h5A5A);                  // R6 invalidate
        op(0, 8'h35, 0, 3, 0, 0, 0, "R6");
        snoop(0, 8'h12, 0);                         // R7 snooped read
        op(0, 8'h12, 0, 0, 0, 0, 0, "R7");
        snoop(1, 8'h22, 16'h7777);                  // R7 same index, other tag
        op(0, 8'h12, 0, 0, 0, 0, 0, "R7");
        op(0, 8'h12, 0, 0, 1, 8'h12, 16'hC0DE, "R9"); // collision in lookup
        op(0, 8'h12, 0, 0, 0, 0, 0, "R9");
        op(1, 8'h40, 16'h0F0F, 4, 0, 0, 0, "R8");
        lfsr = 16'hACE1;
        for (int n = 0; n < 80; n++) begin
            logic [AW-1:0] ra;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ra = {lfsr[9], 2'b00, lfsr[8], 2'b00, lfsr[1:0]};
            case (lfsr[4:2])
                3'd0, 3'd1, 3'd2: op(0, ra, 0, int'(lfsr[6:5]), 0, 0, 0, "R3");
                3'd3, 3'd4: op(1, ra, lfsr ^ 16'h3C3C, int'(lfsr[6:5]), 0, 0, 0, "R4");
                3'd5: snoop(1, ra, lfsr ^ 16'h9999);
                3'd6: snoop(0, ra, 0);
                default: op(0, ra, 0, 0, 1, ra, lfsr ^ 16'h4242, "R9");
            endcase
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule